// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block is the device-side command front end of a NAND flash memory. Every write strobe carries one byte on an 8-bit input bus. Two latch qualifiers, command-latch and address-latch, mark that byte as a command, an address cycle or a data byte. The sequencer recognises the two-phase read, program and erase sequences, the random-column change, the ID read, the status read and reset. It collects column and row address bytes into staging registers. It holds a ready flag low for a programmable number of clock cycles, and it presents status, ID or page data on the output bus. Each read strobe steps to the next ID or data byte.

The memory array is not modelled. A small page buffer stands in for the data register. It is indexed by the low bits of the column pointer, so program data can be read back. All activity is synchronous to one clock. Both strobes are single-cycle enables that are sampled on the rising edge.

Top module: `nfc_seq`

## Requirements
- R1: After reset, ready is 1, the output mode is status, col_addr and row_addr are 0, and every page buffer byte reads FFh.
- R2: Command 00h, five address cycles and then 30h commit both addresses and set data output at the committed column. Ready drops on the 30h edge and stays low for exactly busy_cycles cycles; a value of 0 counts as 1.
- R3: The five address cycles carry, in this order: column bits 7:0, column bits 11:8 (from bus bits 3:0), row bits 7:0, row bits 15:8, and row bit 16 (from bus bit 0). Row bits 5:0 are the page within a block and row bits 16:6 are the block.
- R4: Command 80h with five address cycles commits the addresses. The data bytes that follow go to buffer entries col, col+1, and so on (modulo the buffer depth). Confirm 10h then starts a busy period as in R2, and a later read returns those bytes.
- R5: Command 60h with three row cycles (row bits 7:0, 15:8, 16) followed by D0h commits row_addr, leaves col_addr unchanged, and starts a busy period.
- R6: While page data is being output, command 05h, two column cycles and E0h move col_addr and the read pointer to the new column, with no busy period.
- R7: Command 90h with one address cycle makes successive read strobes return 98h, DAh, the three ID parameters, and then 00h.
- R8: While ready is 0, every command other than 70h and FFh is ignored, as are address and data cycles.
- R9: An address cycle that arrives after the sequence already has all its address cycles changes nothing.
- R10: With wr_protect_n low, 10h and D0h start no busy period and set the fail bit. A drop of wr_protect_n during a program or erase busy period ends it on the next edge and sets the fail bit. A started program or erase clears the fail bit.
- R11: The status byte is {wr_protect_n, ready, 5'b0, fail}, for example C0h for an idle, unprotected device with no failure.
- R12: An unknown byte, or a confirm command that arrives out of sequence, returns the sequencer to idle and leaves col_addr and row_addr unchanged.
- R13: Command FFh during a busy period ends it, so ready is 1 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe; samples io_in |
| rd_stb | input | 1 | Read strobe; advances the ID or data pointer |
| cmd_lat | input | 1 | Marks the strobed byte as a command |
| addr_lat | input | 1 | Marks the strobed byte as an address cycle |
| io_in | input | 8 | Input byte |
| wr_protect_n | input | 1 | Low blocks and aborts program and erase |
| busy_cycles | input | 8 | Length of a busy period in cycles |
| io_out | output | 8 | Status, ID or data byte |
| ready | output | 1 | 1 when no operation is in progress |
| col_addr | output | 12 | Committed column address |
| row_addr | output | 17 | Committed row address |

## Verification
Command, address and data strobes take effect on the edge that samples them. Committed addresses, output mode and fail state can therefore be seen half a cycle later, at the falling edge after the strobe. The bench drives on falling edges and samples there.

Ready goes low on the confirm edge. The bench counts the falling edges from that point until ready returns and compares the count with busy_cycles, taking 0 as 1. An abort by reset command or write-protect is due one edge after the event.

io_out depends on its state without a register, so the bench reads each byte in the half cycle before the read strobe that advances it.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;
  localparam int COL_W = 12;
  localparam int ROW_W = 17;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_CONF, ST_DATA} seq_t;
  typedef enum logic [2:0] {OP_READ, OP_PROG, OP_ERASE, OP_RCOL, OP_ID} op_t;
  typedef enum logic [1:0] {OUT_STATUS, OUT_ID, OUT_DATA} out_t;

  localparam logic [7:0] C_RD    = 8'h00;
  localparam logic [7:0] C_RD_GO = 8'h30;
  localparam logic [7:0] C_PG    = 8'h80;
  localparam logic [7:0] C_PG_GO = 8'h10;
  localparam logic [7:0] C_ER    = 8'h60;
  localparam logic [7:0] C_ER_GO = 8'hD0;
  localparam logic [7:0] C_RC    = 8'h05;
  localparam logic [7:0] C_RC_GO = 8'hE0;
  localparam logic [7:0] C_ID    = 8'h90;
  localparam logic [7:0] C_ST    = 8'h70;
  localparam logic [7:0] C_RST   = 8'hFF;

  // index of the final address cycle for each operation
  function automatic logic [2:0] addr_last(op_t op);
    case (op)
      OP_READ, OP_PROG: return 3'd4;
      OP_ERASE:         return 3'd2;
      OP_RCOL:          return 3'd1;
      default:          return 3'd0;
    endcase
  endfunction

  // erase carries row bytes only, so its cycles land two slots later
  function automatic logic [2:0] addr_slot(op_t op, logic [2:0] n);
    return (op == OP_ERASE) ? n + 3'd2 : n;
  endfunction

  function automatic logic [7:0] status_byte(logic wp_n, logic rdy, logic fail);
    return {wp_n, rdy, 5'b0, fail};
  endfunction
endpackage

// File: rtl/nfc_busy_timer.sv
`timescale 1ns/1ps
module nfc_busy_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load,
  input  logic         abort,
  output logic         ready
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (abort)            cnt <= '0;
    else if (start)            cnt <= (load == '0) ? W'(1) : load;
    else if (cnt != '0)        cnt <= cnt - W'(1);
  end

  assign ready = (cnt == '0);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> !ready);
  // R13
  busy_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> ready);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);
endmodule

// File: rtl/nfc_page_buf.sv
`timescale 1ns/1ps
module nfc_page_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nfc_seq.sv
`timescale 1ns/1ps
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int          BUF_DEPTH = 64,
  parameter int          BUSY_W    = 8,
  parameter logic [7:0]  ID3       = 8'h95,
  parameter logic [7:0]  ID4       = 8'h44,
  parameter logic [7:0]  ID5       = 8'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              cmd_lat,
  input  logic              addr_lat,
  input  logic [7:0]        io_in,
  input  logic              wr_protect_n,
  input  logic [BUSY_W-1:0] busy_cycles,
  output logic [7:0]        io_out,
  output logic              ready,
  output logic [COL_W-1:0]  col_addr,
  output logic [ROW_W-1:0]  row_addr
);
  localparam int BUF_AW = $clog2(BUF_DEPTH);

  seq_t st;
  op_t  op;
  out_t om;
  logic [2:0]       acnt, id_idx;
  logic [COL_W-1:0] col_stg, col_nx, col_q, wr_ptr, rd_ptr;
  logic [ROW_W-1:0] row_stg, row_nx, row_q;
  logic             fail_q, busy_pe;
  logic [7:0]       buf_rd;

  // named events for the assertions
  logic cmd_evt, adr_evt, dat_evt, live_cmd, cmd_ok, unk_evt;
  logic go_read, go_pe, start_busy, wp_abort, abort, adr_live, dat_live, last_adr;

  assign cmd_evt  = wr_stb & cmd_lat & ~addr_lat;
  assign adr_evt  = wr_stb & addr_lat & ~cmd_lat;
  assign dat_evt  = wr_stb & ~cmd_lat & ~addr_lat;
  assign live_cmd = cmd_evt & ready;

  always_comb begin
    case (io_in)
      C_RD, C_PG, C_ER, C_ID, C_ST, C_RST: cmd_ok = 1'b1;
      C_RC:    cmd_ok = (om == OUT_DATA);
      C_RD_GO: cmd_ok = (st == ST_CONF) && (op == OP_READ);
      C_PG_GO: cmd_ok = (st == ST_DATA) && (op == OP_PROG);
      C_ER_GO: cmd_ok = (st == ST_CONF) && (op == OP_ERASE);
      C_RC_GO: cmd_ok = (st == ST_CONF) && (op == OP_RCOL);
      default: cmd_ok = 1'b0;
    endcase
  end

  assign unk_evt    = live_cmd & ~cmd_ok;
  assign go_read    = live_cmd & cmd_ok & (io_in == C_RD_GO);
  assign go_pe      = live_cmd & cmd_ok & wr_protect_n & ((io_in == C_PG_GO) | (io_in == C_ER_GO));
  assign start_busy = go_read | go_pe;
  assign wp_abort   = ~ready & busy_pe & ~wr_protect_n;
  assign abort      = wp_abort | (cmd_evt & ~ready & (io_in == C_RST));
  assign adr_live   = adr_evt & ready & (st == ST_ADDR);
  assign last_adr   = (acnt == addr_last(op));
  assign dat_live   = dat_evt & ready & (st == ST_DATA);

  // place the current address byte into the staging copy
  always_comb begin
    col_nx = col_stg;
    row_nx = row_stg;
    case (addr_slot(op, acnt))
      3'd0: col_nx[7:0]   = io_in;
      3'd1: col_nx[11:8]  = io_in[3:0];
      3'd2: row_nx[7:0]   = io_in;
      3'd3: row_nx[15:8]  = io_in;
      3'd4: row_nx[16]    = io_in[0];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; op <= OP_READ; om <= OUT_STATUS;
      acnt <= '0; id_idx <= '0;
      col_stg <= '0; row_stg <= '0; col_q <= '0; row_q <= '0;
      wr_ptr <= '0; rd_ptr <= '0; fail_q <= 1'b0; busy_pe <= 1'b0;
    end else begin
      if (start_busy) busy_pe <= go_pe;
      if (abort) busy_pe <= 1'b0;
      if (wp_abort) fail_q <= 1'b1;

      if (cmd_evt && !ready) begin
        if (io_in == C_ST) om <= OUT_STATUS;
        if (io_in == C_RST) begin st <= ST_IDLE; om <= OUT_STATUS; end
      end else if (unk_evt) begin
        st <= ST_IDLE;
      end else if (live_cmd) begin
        case (io_in)
          C_RD: begin st <= ST_ADDR; op <= OP_READ;  acnt <= '0; end
          C_PG: begin st <= ST_ADDR; op <= OP_PROG;  acnt <= '0; end
          C_ER: begin st <= ST_ADDR; op <= OP_ERASE; acnt <= '0; end
          C_ID: begin st <= ST_ADDR; op <= OP_ID;    acnt <= '0; end
          C_RC: begin st <= ST_ADDR; op <= OP_RCOL;  acnt <= '0; end
          C_RD_GO: begin
            st <= ST_IDLE; col_q <= col_stg; row_q <= row_stg;
            rd_ptr <= col_stg; om <= OUT_DATA;
          end
          C_PG_GO: begin st <= ST_IDLE; fail_q <= ~wr_protect_n; end
          C_ER_GO: begin
            st <= ST_IDLE; fail_q <= ~wr_protect_n;
            if (wr_protect_n) row_q <= row_stg;
          end
          C_RC_GO: begin
            st <= ST_IDLE; col_q <= col_stg; rd_ptr <= col_stg; om <= OUT_DATA;
          end
          C_ST:  om <= OUT_STATUS;
          C_RST: begin st <= ST_IDLE; om <= OUT_STATUS; end
          default: ;
        endcase
      end

      if (adr_live) begin
        if (op != OP_ID) begin col_stg <= col_nx; row_stg <= row_nx; end
        acnt <= acnt + 3'd1;
        if (last_adr) begin
          case (op)
            OP_PROG: begin
              st <= ST_DATA; col_q <= col_nx; row_q <= row_nx; wr_ptr <= col_nx;
            end
            OP_ID:   begin st <= ST_IDLE; om <= OUT_ID; id_idx <= '0; end
            default: st <= ST_CONF;
          endcase
        end
      end

      if (dat_live) wr_ptr <= wr_ptr + COL_W'(1);

      if (rd_stb) begin
        if (om == OUT_ID && id_idx < 3'd5) id_idx <= id_idx + 3'd1;
        if (om == OUT_DATA) rd_ptr <= rd_ptr + COL_W'(1);
      end
    end
  end

  nfc_busy_timer #(.W(BUSY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_busy), .load(busy_cycles),
    .abort(abort), .ready(ready)
  );

  nfc_page_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(dat_live), .waddr(wr_ptr[BUF_AW-1:0]),
    .wdata(io_in), .raddr(rd_ptr[BUF_AW-1:0]), .rdata(buf_rd)
  );

  always_comb begin
    case (om)
      OUT_ID: begin
        case (id_idx)
          3'd0: io_out = 8'h98;
          3'd1: io_out = 8'hDA;
          3'd2: io_out = ID3;
          3'd3: io_out = ID4;
          3'd4: io_out = ID5;
          default: io_out = 8'h00;
        endcase
      end
      OUT_DATA: io_out = buf_rd;
      default:  io_out = status_byte(wr_protect_n, ready, fail_q);
    endcase
  end

  assign col_addr = col_q;
  assign row_addr = row_q;

  // R12
  unk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unk_evt |=> (st == ST_IDLE) && $stable(col_q) && $stable(row_q));
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_evt && !ready && io_in != C_ST && io_in != C_RST) |=> $stable(st) && $stable(op) && $stable(om));
  // R9
  extra_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_evt && st != ST_ADDR) |=> $stable(col_q) && $stable(row_q) && $stable(st));
  // R10
  wp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_protect_n && busy_pe && !ready) |=> ready && fail_q);
endmodule

// File: tb/nfc_seq_test.sv
`timescale 1ns/1ps
module nfc_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_stb = 0, rd_stb = 0, cmd_lat = 0, addr_lat = 0, wr_protect_n = 1;
  logic [7:0] io_in = 0, busy_cycles = 8'd5;
  logic [7:0] io_out;
  logic ready;
  logic [11:0] col_addr;
  logic [16:0] row_addr;
  int vec = 0, fails = 0;
  logic [7:0] model [64];

  always #2.5 clk = ~clk;

  nfc_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .cmd_lat(cmd_lat),
    .addr_lat(addr_lat), .io_in(io_in), .wr_protect_n(wr_protect_n),
    .busy_cycles(busy_cycles), .io_out(io_out), .ready(ready),
    .col_addr(col_addr), .row_addr(row_addr)
  );

  function automatic logic [7:0] stat(logic wp, logic rdy, logic fl);
    return {wp, rdy, 5'b0, fl};
  endfunction
  function automatic int eff(logic [7:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic put(logic c, logic a, logic [7:0] b);
    @(negedge clk); cmd_lat = c; addr_lat = a; io_in = b; wr_stb = 1;
    @(negedge clk); wr_stb = 0; cmd_lat = 0; addr_lat = 0;
  endtask
  task automatic cmd(logic [7:0] b); put(1, 0, b); endtask
  task automatic adr(logic [7:0] b); put(0, 1, b); endtask
  task automatic dat(logic [7:0] b); put(0, 0, b); endtask
  task automatic addr5(logic [11:0] c, logic [16:0] r);
    adr(c[7:0]); adr({4'b0, c[11:8]}); adr(r[7:0]); adr(r[15:8]); adr({7'b0, r[16]});
  endtask
  task automatic rd(output logic [7:0] v);
    @(negedge clk); v = io_out; rd_stb = 1;
    @(negedge clk); rd_stb = 0;
  endtask
  task automatic wait_rdy(output int k);
    k = 0;
    while (!ready && k < 5000) begin @(negedge clk); k++; end
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

  initial begin
    int k;
    logic [7:0] v;
    int seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", ready, 1);
    chk("R1 status", io_out, 8'hC0);
    chk("R1 col", col_addr, 0);
    chk("R1 row", row_addr, 0);

    // R7 ID read
    cmd(8'h90); adr(8'h00);
    rd(v); chk("R7 id0", v, 8'h98);
    rd(v); chk("R7 id1", v, 8'hDA);
    rd(v); chk("R7 id2", v, 8'h95);
    rd(v); chk("R7 id3", v, 8'h44);
    rd(v); chk("R7 id4", v, 8'h81);
    rd(v); chk("R7 past end", v, 8'h00);

    // R4 R3 program with address layout
    cmd(8'h80); addr5(12'h123, 17'h1ABCD);
    chk("R3 col", col_addr, 12'h123);
    chk("R3 row", row_addr, 17'h1ABCD);
    for (int i = 0; i < 4; i++) begin dat(8'hA0 + 8'(i)); model[(8'h23 + i) % 64] = 8'hA0 + 8'(i); end
    cmd(8'h10);
    chk("R4 busy on confirm", ready, 0);
    wait_rdy(k); chk("R4 busy length", k, 5);
    cmd(8'h70); chk("R11 status after pass", io_out, 8'hC0);

    // R2 read back
    cmd(8'h00); addr5(12'h123, 17'h00F00); cmd(8'h30);
    chk("R2 busy on confirm", ready, 0);
    wait_rdy(k); chk("R2 busy length", k, 5);
    chk("R2 row commit", row_addr, 17'h00F00);
    for (int i = 0; i < 4; i++) begin rd(v); chk("R4 readback", v, 8'hA0 + 8'(i)); end

    // R6 random column
    cmd(8'h05); adr(8'h25); adr(8'h01); cmd(8'hE0);
    chk("R6 ready", ready, 1);
    chk("R6 col", col_addr, 12'h125);
    rd(v); chk("R6 data", v, 8'hA2);

    // R5 erase
    cmd(8'h60); adr(8'h41); adr(8'h40); adr(8'h00); cmd(8'hD0);
    chk("R5 row", row_addr, 17'h04041);
    chk("R5 col kept", col_addr, 12'h125);
    chk("R5 block", row_addr[16:6], 11'h101);
    wait_rdy(k); chk("R5 busy length", k, 5);

    // R8 busy rejects commands, status reads busy
    busy_cycles = 8'd40;
    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h01); cmd(8'hD0);
    cmd(8'h00); adr(8'h77); cmd(8'h80);
    cmd(8'h70);
    chk("R11 status busy", io_out, 8'h80);
    wait_rdy(k);
    chk("R8 row kept", row_addr, 17'h10000);
    chk("R8 col kept", col_addr, 12'h125);
    cmd(8'h30);
    chk("R8 no read started", ready, 1);

    // R13 reset aborts
    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
    chk("R13 busy", ready, 0);
    cmd(8'hFF);
    chk("R13 ready after reset", ready, 1);

    // R9 sixth address ignored
    busy_cycles = 8'd0;
    cmd(8'h00); addr5(12'h010, 17'h00777); adr(8'h3F); cmd(8'h30);
    chk("R9 col", col_addr, 12'h010);
    chk("R9 row", row_addr, 17'h00777);
    wait_rdy(k); chk("R2 zero count", k, 1);

    // R12 unknown command
    cmd(8'h00); adr(8'h55); adr(8'h05); cmd(8'h42);
    chk("R12 col kept", col_addr, 12'h010);
    cmd(8'h30);
    chk("R12 confirm ignored", ready, 1);
    chk("R12 row kept", row_addr, 17'h00777);

    // R10 write protect
    busy_cycles = 8'd40;
    wr_protect_n = 0;
    cmd(8'h80); addr5(12'h000, 17'h00001); cmd(8'h10);
    chk("R10 no program", ready, 1);
    cmd(8'h70); chk("R10 status fail", io_out, 8'h41);
    cmd(8'h60); adr(8'h80); adr(8'h00); adr(8'h00); cmd(8'hD0);
    chk("R10 no erase", ready, 1);
    chk("R10 row kept", row_addr, 17'h00001);
    wr_protect_n = 1;
    cmd(8'h60); adr(8'h80); adr(8'h00); adr(8'h00); cmd(8'hD0);
    chk("R10 erase started", ready, 0);
    repeat (3) @(negedge clk);
    wr_protect_n = 0;
    @(negedge clk);
    chk("R10 abort", ready, 1);
    wr_protect_n = 1;
    cmd(8'h70); chk("R11 R10 status", io_out, 8'hC1);

    // random program and read back
    for (int it = 0; it < 16; it++) begin
      logic [11:0] c;
      logic [16:0] r;
      int len;
      c = 12'($urandom);
      r = 17'($urandom);
      len = 1 + int'($urandom % 6);
      busy_cycles = 8'($urandom % 12);
      cmd(8'h80); addr5(c, r);
      for (int i = 0; i < len; i++) begin
        logic [7:0] d;
        d = 8'($urandom);
        dat(d);
        model[(int'(c) + i) % 64] = d;
      end
      cmd(8'h10);
      wait_rdy(k); chk("R4 random busy", k, eff(busy_cycles));
      cmd(8'h70); chk("R11 random pass", io_out, stat(1, 1, 0));
      cmd(8'h00); addr5(c, r); cmd(8'h30);
      wait_rdy(k); chk("R2 random busy", k, eff(busy_cycles));
      chk("R3 random col", col_addr, c);
      chk("R3 random row", row_addr, r);
      for (int i = 0; i < len + 1; i++) begin
        rd(v); chk("R4 random data", v, model[(int'(c) + i) % 64]);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end
endmodule